// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic Logic Unit with Signed Overflow

This block is a purely combinational arithmetic logic unit for a 16-bit datapath. Two operand words and a 4-bit operation selector go in. One result word and a single overflow flag come out in the same cycle. The operation set covers these groups:

- add and subtract, in unsigned and two's-complement flavours;
- bitwise AND, OR, XOR and inversion;
- an upper-half immediate load;
- less-than compares, unsigned and signed.

All adds, subtracts and compares share one carry chain. The signed compare stays correct when the difference it is based on overflows. The overflow flag means something only for the two signed arithmetic operations and reads 0 for every other code, including codes that have no operation assigned.

Top module: `word_alu`

## Requirements
- R1: Selector 0 (unsigned add) gives result = (A + B) mod 2^16 and overflow 0, even when a carry leaves bit 15.
- R2: Selector 1 (unsigned subtract) gives result = (A - B) mod 2^16 and overflow 0, even when a borrow occurs.
- R3: Selector 2 gives A AND B, selector 3 gives A OR B, and selector 5 gives A XOR B, each with overflow 0.
- R4: Selector 4 gives the bitwise inversion of A; B has no effect on the result.
- R5: Selector 6 gives a result whose bits 15..8 equal A bits 7..0 and whose bits 7..0 are 0; B has no effect on the result.
- R6: Selector 7 gives 1 when A < B as unsigned numbers and 0 otherwise; bits 15..1 of the result are 0.
- R7: Selector 15 gives 1 when A < B as two's-complement numbers and 0 otherwise, including when A - B overflows; bits 15..1 of the result are 0.
- R8: Selector 8 (signed add) gives result = (A + B) mod 2^16. Overflow is 1 exactly when A and B have the same sign and the sum's sign differs from it.
- R9: Selector 9 (signed subtract) gives result = (A - B) mod 2^16. Overflow is 1 exactly when A and B have different signs and the result's sign differs from A's sign.
- R10: Selectors 10 through 14 give result 0 and overflow 0.
- R11: Overflow is 0 for every selector other than 8 and 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand (A) |
| opnd_b | input | 16 | Second operand (B) |
| op_sel | input | 4 | Operation selector |
| result | output | 16 | Result word |
| ovf | output | 1 | Signed overflow flag |

## Verification
The bench builds the block with its default width of 16, so the operand-half split used by the immediate load lands at bit 8. The extreme values 0x7FFF, 0x8000, 0x0000 and 0xFFFF also lie directly at the sign and carry boundaries. At this width, directed pairs can force a signed overflow in both directions for add, subtract and the signed compare. Seeded random operands then sweep all sixteen selector codes, including the five unassigned ones.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADDU = 4'd0,
    OP_SUBU = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOT  = 4'd4,
    OP_XOR  = 4'd5,
    OP_LUP  = 4'd6,
    OP_LTU  = 4'd7,
    OP_ADDS = 4'd8,
    OP_SUBS = 4'd9,
    OP_LTS  = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
// Shared add/subtract carry chain with two's-complement overflow detect.
module alu_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             s_ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;

  always_comb begin
    b_eff          = sub ? ~b : b;
    {carry, sum}   = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    // operands (after inversion) agree in sign, result disagrees
    s_ovf          = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end
endmodule

// File: rtl/alu_logic.sv
// Bitwise operations and the upper-half immediate load.
module alu_logic #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       sel,
  output logic [WIDTH-1:0] y
);
  import alu_pkg::*;

  localparam int HALF = WIDTH / 2;
  localparam int REST = WIDTH - HALF;

  logic [WIDTH-1:0] upper_load;

  assign upper_load = {a[HALF-1:0], {REST{1'b0}}};

  always_comb begin
    case (alu_op_e'(sel))
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      OP_LUP:  y = upper_load;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_compare.sv
// Less-than flags derived from the shared subtraction.
module alu_compare (
  input  logic diff_msb,
  input  logic carry,
  input  logic s_ovf,
  output logic lt_s,
  output logic lt_u
);
  always_comb begin
    lt_u = ~carry;            // borrow out of A - B
    lt_s = diff_msb ^ s_ovf;  // sign corrected for overflow
  end
endmodule

// File: rtl/word_alu.sv
module word_alu #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [3:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             ovf
);
  import alu_pkg::*;

  localparam int MSB = WIDTH - 1;

  logic             do_sub;
  logic [WIDTH-1:0] arith;
  logic             carry;
  logic             s_ovf;
  logic [WIDTH-1:0] bitwise;
  logic             lt_s;
  logic             lt_u;

  always_comb begin
    case (alu_op_e'(op_sel))
      OP_SUBU, OP_SUBS, OP_LTU, OP_LTS: do_sub = 1'b1;
      default:                          do_sub = 1'b0;
    endcase
  end

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a     (opnd_a),
    .b     (opnd_b),
    .sub   (do_sub),
    .sum   (arith),
    .carry (carry),
    .s_ovf (s_ovf)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a   (opnd_a),
    .b   (opnd_b),
    .sel (op_sel),
    .y   (bitwise)
  );

  alu_compare u_cmp (
    .diff_msb (arith[MSB]),
    .carry    (carry),
    .s_ovf    (s_ovf),
    .lt_s     (lt_s),
    .lt_u     (lt_u)
  );

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    case (alu_op_e'(op_sel))
      OP_ADDU, OP_SUBU: result = arith;
      OP_ADDS, OP_SUBS: begin
        result = arith;
        ovf    = s_ovf;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_LUP: result = bitwise;
      OP_LTU:  result = {{(WIDTH-1){1'b0}}, lt_u};
      OP_LTS:  result = {{(WIDTH-1){1'b0}}, lt_s};
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/word_alu_chk.sv
module word_alu_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             ovf
);
  localparam int HALF = WIDTH / 2;
  localparam int MSB  = WIDTH - 1;

  always_comb begin
    if (op_sel != 4'd8 && op_sel != 4'd9) begin
      // R11
      no_overflow_chk: assert (!ovf);
    end
    if (op_sel >= 4'd10 && op_sel <= 4'd14) begin
      // R10
      unused_zero_chk: assert (result == '0);
    end
    if (op_sel == 4'd6) begin
      // R5
      upper_load_chk: assert (result[HALF-1:0] == '0 && result[MSB:HALF] == opnd_a[HALF-1:0]);
    end
    if (op_sel == 4'd7 || op_sel == 4'd15) begin
      // R6 R7
      compare_ext_chk: assert (result[MSB:1] == '0);
    end
    if (op_sel == 4'd4) begin
      // R4
      invert_chk: assert ((result ^ opnd_a) == {WIDTH{1'b1}});
    end
    if (op_sel == 4'd8 && opnd_a[MSB] != opnd_b[MSB]) begin
      // R8
      mixed_sign_add_chk: assert (!ovf);
    end
  end
endmodule

bind word_alu word_alu_chk #(.WIDTH(WIDTH)) i_chk (
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .op_sel (op_sel),
  .result (result),
  .ovf    (ovf)
);

// File: tb/test_word_alu.sv
module test_word_alu;
  logic        clk;
  logic        rst_n;
  logic [15:0] a, b;
  logic [3:0]  op;
  logic [15:0] result;
  logic        ovf;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  word_alu i_word_alu (
    .opnd_a (a),
    .opnd_b (b),
    .op_sel (op),
    .result (result),
    .ovf    (ovf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int sval(input logic [15:0] v);
    return v[15] ? int'(v) - 65536 : int'(v);
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd5: return "R3";
      4'd4: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R8";
      4'd9: return "R9";
      4'd15: return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic void model(input logic [15:0] x, input logic [15:0] y,
                                input logic [3:0] o,
                                output logic [15:0] r, output logic v);
    int s;
    r = 16'h0;
    v = 1'b0;
    case (o)
      4'd0, 4'd8: begin
        r = 16'((int'(x) + int'(y)) & 32'hFFFF);
        s = sval(x) + sval(y);
        if (o == 4'd8) v = (s > 32767) || (s < -32768);
      end
      4'd1, 4'd9: begin
        r = 16'((int'(x) - int'(y)) & 32'hFFFF);
        s = sval(x) - sval(y);
        if (o == 4'd9) v = (s > 32767) || (s < -32768);
      end
      4'd2: r = x & y;
      4'd3: r = x | y;
      4'd4: r = ~x;
      4'd5: r = x ^ y;
      4'd6: r = {x[7:0], 8'h00};
      4'd7: r = (int'(x) < int'(y)) ? 16'd1 : 16'd0;
      4'd15: r = (sval(x) < sval(y)) ? 16'd1 : 16'd0;
      default: ;
    endcase
  endfunction

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic [3:0] o,
                       input string note);
    logic [15:0] er;
    logic ev;
    @(posedge clk);
    a = x; b = y; op = o;
    @(negedge clk);
    model(x, y, o, er, ev);
    checks++;
    if (result !== er) begin
      errors++;
      $display("FAIL %s %s result: a=%h b=%h op=%0d got %h expected %h",
               req_of(o), note, x, y, o, result, er);
    end
    checks++;
    if (ovf !== ev) begin
      errors++;
      $display("FAIL %s %s ovf: a=%h b=%h op=%0d got %b expected %b",
               (o == 4'd8 || o == 4'd9) ? req_of(o) : "R11", note, x, y, o, ovf, ev);
    end
  endtask

  initial begin
    int unsigned seed_dummy;
    a = '0; b = '0; op = '0; rst_n = 1'b0;
    seed_dummy = $urandom(32'd351);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    apply(16'h0000, 16'h0000, 4'd0, "idle zeros");
    apply(16'hFFFF, 16'h0001, 4'd0, "R1 carry out");
    apply(16'h0000, 16'h0001, 4'd1, "R2 borrow");
    apply(16'hF0F0, 16'hFF00, 4'd2, "R3 and");
    apply(16'hF0F0, 16'h0F0F, 4'd3, "R3 or");
    apply(16'hAAAA, 16'hFFFF, 4'd5, "R3 xor");
    apply(16'h1234, 16'h0000, 4'd4, "R4 b=0");
    apply(16'h1234, 16'hFFFF, 4'd4, "R4 b ignored");
    apply(16'h12AB, 16'h0000, 4'd6, "R5 b=0");
    apply(16'h12AB, 16'hBEEF, 4'd6, "R5 b ignored");
    apply(16'h0001, 16'h8000, 4'd7, "R6 unsigned lt");
    apply(16'h8000, 16'h0001, 4'd7, "R6 unsigned ge");
    apply(16'h5555, 16'h5555, 4'd7, "R6 equal");
    apply(16'h8000, 16'h0001, 4'd15, "R7 overflowing diff");
    apply(16'h7FFF, 16'h8000, 4'd15, "R7 overflowing diff ge");
    apply(16'hFFFF, 16'h0000, 4'd15, "R7 negative lt");
    apply(16'h7FFF, 16'h0001, 4'd8, "R8 pos overflow");
    apply(16'h8000, 16'h8000, 4'd8, "R8 neg overflow");
    apply(16'h7FFF, 16'h8000, 4'd8, "R8 mixed signs");
    apply(16'h8000, 16'h0001, 4'd9, "R9 neg overflow");
    apply(16'h7FFF, 16'hFFFF, 4'd9, "R9 pos overflow");
    apply(16'h0005, 16'h0007, 4'd9, "R9 no overflow");
    apply(16'h7FFF, 16'h0001, 4'd0, "R11 unsigned add no flag");
    apply(16'h8000, 16'h0001, 4'd1, "R11 unsigned sub no flag");
    for (int k = 10; k <= 14; k++) apply(16'hFFFF, 16'h7FFF, 4'(k), "R10 unused");
    for (int i = 0; i < 3000; i++)
      apply(16'($urandom), 16'($urandom), 4'($urandom), "random");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule